// File: doc/BRIEF.md
# Processor Bus Data Parity Generator and Checker

This block looks after data parity on a 64-bit processor data bus. It has eight byte lanes, and each lane carries one odd-parity bit.

When the bridge drives data onto the bus, the block computes the outgoing parity. It also says when that parity has to be presented:
- In a master write, the parity is presented while data-bus-busy is high.
- In a slave read, the parity is presented in the cycle that carries transfer-acknowledge.

When the bridge receives data, the block checks the incoming parity against the data. This happens in master reads and slave writes, on every cycle in which transfer-acknowledge is high.

A failed check sets a sticky error status. It also captures three pieces of context: the address, the transfer attributes and the failing lanes. The error then drives either an interrupt or a machine-check output, as chosen by a routing control. The status is cleared with a write-one pulse. While the status is set, the capture registers are frozen. A further error during that time raises an overflow flag. A global enable turns checking off completely.

Top module: `bus_parity_guard`

## Requirements
- R1: After synchronous reset, the following are all zero: err_sts, err_ovf, err_lane, err_addr, err_attr, irq and mcp.
- R2: Each bit par_out[i] is the odd parity of data_out[8i+7:8i]. It is combinational, so the byte plus its parity bit always holds an odd number of ones.
- R3: par_drive is high in two cases and low otherwise:
  - role is 1 (master write) and dbb is high;
  - role is 2 (slave read) and ta is high.
- R4: A lane error occurs when all of the following hold in the same cycle:
  - role is 0 (master read) or 3 (slave write);
  - ta is high;
  - chk_en is high;
  - data_in byte i together with par_in[i] holds an even number of ones.
- R5: If a lane error occurs in a cycle while err_sts is low, then after that clock edge:
  - err_sts is 1 and err_ovf is 0;
  - err_addr and err_attr hold that cycle's addr and attr;
  - err_lane holds the mask of the failing lanes.
- R6: A lane error while err_sts is high and sts_clr is low sets err_ovf. It leaves err_addr, err_attr and err_lane unchanged.
- R7: sts_clr high clears err_sts and err_ovf at the next edge. If a lane error occurs in the same cycle, the error wins: err_sts is set, the context is captured anew and err_ovf ends at 0.
- R8: The outputs follow err_sts and mc_sel:
  - irq equals err_sts with mc_sel low;
  - mcp equals err_sts with mc_sel high;
  - irq and mcp are never high together.
- R9: With chk_en low, bad parity changes no status, capture or event output.
- R10: Bad parity is ignored in source roles (1 and 2) and in cycles without ta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role | input | 2 | Cycle role: 0 master read, 1 master write, 2 slave read, 3 slave write |
| dbb | input | 1 | Data-bus-busy strobe |
| ta | input | 1 | Transfer-acknowledge strobe |
| data_out | input | 64 | Data the bridge sources |
| par_out | output | 8 | Generated odd parity per byte lane |
| par_drive | output | 1 | Generated parity is valid on the bus |
| data_in | input | 64 | Data the bridge receives |
| par_in | input | 8 | Received parity per byte lane |
| addr | input | 32 | Address of the current transfer |
| attr | input | 8 | Attributes of the current transfer |
| chk_en | input | 1 | Global parity check enable |
| mc_sel | input | 1 | Error routing: 0 interrupt, 1 machine check |
| sts_clr | input | 1 | Write-one-to-clear pulse for the status and overflow bits |
| err_sts | output | 1 | Sticky parity error status |
| err_ovf | output | 1 | Further error occurred while the status was set |
| err_lane | output | 8 | Captured failing lane mask |
| err_addr | output | 32 | Captured address |
| err_attr | output | 8 | Captured attributes |
| irq | output | 1 | Interrupt request |
| mcp | output | 1 | Machine check request |

## Verification
The bench goes after four cases, each tied to a specific wrong design:
- A clear and an error in the same cycle. A design that let the clear win would lose the error.
- A second error while the status is still set. A design that did not freeze the capture registers would overwrite the first context instead of flagging overflow.
- Bad parity in source roles, in cycles without acknowledge, and with checking disabled. A design that checked too widely would raise false errors here.
- Flipping the routing control while the status is held. A design that latched the route would leave the wrong event output high.

Random roles, strobes and corrupted lanes cover the per-lane parity polarity. They also cover the drive-valid timing for each role.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    localparam int DATA_W = 64;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int ADDR_W = 32;
    localparam int ATTR_W = 8;

    typedef enum logic [1:0] {
        ROLE_MST_RD = 2'd0,
        ROLE_MST_WR = 2'd1,
        ROLE_SLV_RD = 2'd2,
        ROLE_SLV_WR = 2'd3
    } role_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ATTR_W-1:0] attr;
        logic [LANES-1:0]  lanes;
    } err_ctx_t;

    function automatic logic lane_odd(input logic [LANE_W-1:0] b);
        return ~^b;
    endfunction

    function automatic logic role_sources(input role_e r);
        return (r == ROLE_MST_WR) || (r == ROLE_SLV_RD);
    endfunction

    function automatic logic role_sinks(input role_e r);
        return (r == ROLE_MST_RD) || (r == ROLE_SLV_WR);
    endfunction
endpackage

// File: rtl/bpg_par_gen.sv
module bpg_par_gen
    import bpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  role_e             role,
    input  logic              dbb,
    input  logic              ta,
    input  logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  par,
    output logic              drive
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign par[i] = lane_odd(data[i*LANE_W +: LANE_W]);
    end

    always_comb begin
        unique case (role)
            ROLE_MST_WR: drive = dbb;
            ROLE_SLV_RD: drive = ta;
            default:     drive = 1'b0;
        endcase
    end

    // R3
    drive_role_chk: assert property (@(posedge clk) disable iff (rst)
        drive |-> role_sources(role));
endmodule

// File: rtl/bpg_par_chk.sv
module bpg_par_chk
    import bpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  role_e             role,
    input  logic              ta,
    input  logic              chk_en,
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  par,
    output logic [LANES-1:0]  bad_lanes,
    output logic              hit
);
    logic [LANES-1:0] mism;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mism[i] = lane_odd(data[i*LANE_W +: LANE_W]) ^ par[i];
    end

    logic sample;
    assign sample    = chk_en && ta && role_sinks(role);
    assign bad_lanes = sample ? mism : '0;
    assign hit       = |bad_lanes;

    // R9
    no_check_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_en |-> !hit);
    // R10
    hit_needs_ta_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (ta && !role_sources(role)));
endmodule

// File: rtl/bpg_err_log.sv
module bpg_err_log
    import bpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hit,
    input  err_ctx_t ctx_in,
    input  logic     clr,
    input  logic     mc_sel,
    output logic     sts,
    output logic     ovf,
    output err_ctx_t ctx,
    output logic     irq,
    output logic     mcp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= 1'b0;
            ovf <= 1'b0;
            ctx <= '0;
        end else if (hit) begin
            if (sts && !clr) begin
                ovf <= 1'b1;
            end else begin
                sts <= 1'b1;
                ovf <= 1'b0;
                ctx <= ctx_in;
            end
        end else if (clr) begin
            sts <= 1'b0;
            ovf <= 1'b0;
        end
    end

    assign irq = sts && !mc_sel;
    assign mcp = sts && mc_sel;

    // R5
    rise_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts) |-> $past(hit));
    // R6
    frozen_ctx_chk: assert property (@(posedge clk) disable iff (rst)
        (sts && $past(sts) && !$past(clr)) |-> $stable(ctx));
    // R6
    ovf_implies_sts_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> sts);
    // R8
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq, mcp}));
endmodule

// File: rtl/bus_parity_guard.sv
module bus_parity_guard
    import bpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        role,
    input  logic              dbb,
    input  logic              ta,
    input  logic [DATA_W-1:0] data_out,
    output logic [LANES-1:0]  par_out,
    output logic              par_drive,
    input  logic [DATA_W-1:0] data_in,
    input  logic [LANES-1:0]  par_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ATTR_W-1:0] attr,
    input  logic              chk_en,
    input  logic              mc_sel,
    input  logic              sts_clr,
    output logic              err_sts,
    output logic              err_ovf,
    output logic [LANES-1:0]  err_lane,
    output logic [ADDR_W-1:0] err_addr,
    output logic [ATTR_W-1:0] err_attr,
    output logic              irq,
    output logic              mcp
);
    role_e            role_q;
    logic [LANES-1:0] bad_lanes;
    logic             hit;
    err_ctx_t         ctx_in;
    err_ctx_t         ctx;

    assign role_q = role_e'(role);

    bpg_par_gen u_gen (
        .clk   (clk),
        .rst   (rst),
        .role  (role_q),
        .dbb   (dbb),
        .ta    (ta),
        .data  (data_out),
        .par   (par_out),
        .drive (par_drive)
    );

    bpg_par_chk u_chk (
        .clk       (clk),
        .rst       (rst),
        .role      (role_q),
        .ta        (ta),
        .chk_en    (chk_en),
        .data      (data_in),
        .par       (par_in),
        .bad_lanes (bad_lanes),
        .hit       (hit)
    );

    assign ctx_in = '{addr: addr, attr: attr, lanes: bad_lanes};

    bpg_err_log u_log (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .ctx_in (ctx_in),
        .clr    (sts_clr),
        .mc_sel (mc_sel),
        .sts    (err_sts),
        .ovf    (err_ovf),
        .ctx    (ctx),
        .irq    (irq),
        .mcp    (mcp)
    );

    assign err_addr = ctx.addr;
    assign err_attr = ctx.attr;
    assign err_lane = ctx.lanes;
endmodule

// File: tb/tb_bus_parity_guard.sv
module tb_bus_parity_guard;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [1:0]  role = '0;
    logic        dbb = 0, ta = 0, chk_en = 1, mc_sel = 0, sts_clr = 0;
    logic [63:0] data_out = '0, data_in = '0;
    logic [7:0]  par_in = 8'hFF, attr = '0;
    logic [31:0] addr = '0;
    logic [7:0]  par_out, err_lane, err_attr;
    logic        par_drive, err_sts, err_ovf, irq, mcp;
    logic [31:0] err_addr;

    bus_parity_guard dut (
        .clk(clk), .rst(rst), .role(role), .dbb(dbb), .ta(ta),
        .data_out(data_out), .par_out(par_out), .par_drive(par_drive),
        .data_in(data_in), .par_in(par_in), .addr(addr), .attr(attr),
        .chk_en(chk_en), .mc_sel(mc_sel), .sts_clr(sts_clr),
        .err_sts(err_sts), .err_ovf(err_ovf), .err_lane(err_lane),
        .err_addr(err_addr), .err_attr(err_attr), .irq(irq), .mcp(mcp)
    );

    int checks = 0, errors = 0;
    logic        m_sts = 0, m_ovf = 0;
    logic [7:0]  m_lane = 0, m_attr = 0;
    logic [31:0] m_addr = 0;

    function automatic logic [7:0] odd_par(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ~^d[i*8 +: 8];
        return p;
    endfunction

    function automatic logic exp_drive(input logic [1:0] r, input logic b, input logic t);
        return (r == 2'd1 && b) || (r == 2'd2 && t);
    endfunction

    function automatic logic [7:0] exp_bad(input logic [1:0] r, input logic t,
                                           input logic en, input logic [63:0] d,
                                           input logic [7:0] p);
        if (!(en && t && (r == 2'd0 || r == 2'd3))) return 8'h00;
        return odd_par(d) ^ p;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        logic [7:0] bad;
        #1;
        chk(par_out == odd_par(data_out), "R2 par_out", 64'(par_out), 64'(odd_par(data_out)));
        chk(par_drive == exp_drive(role, dbb, ta), "R3 par_drive",
            64'(par_drive), 64'(exp_drive(role, dbb, ta)));
        bad = exp_bad(role, ta, chk_en, data_in, par_in);
        if (bad != 0) begin
            if (m_sts && !sts_clr) m_ovf = 1;
            else begin
                m_sts = 1; m_ovf = 0;
                m_addr = addr; m_attr = attr; m_lane = bad;
            end
        end else if (sts_clr) begin
            m_sts = 0; m_ovf = 0;
        end
        @(posedge clk);
        #1;
        chk(err_sts == m_sts, "R5/R7/R9/R10 err_sts", 64'(err_sts), 64'(m_sts));
        chk(err_ovf == m_ovf, "R6 err_ovf", 64'(err_ovf), 64'(m_ovf));
        chk(err_lane == m_lane, "R4 err_lane", 64'(err_lane), 64'(m_lane));
        chk(err_addr == m_addr, "R5/R6 err_addr", 64'(err_addr), 64'(m_addr));
        chk(err_attr == m_attr, "R5/R6 err_attr", 64'(err_attr), 64'(m_attr));
        chk(irq == (m_sts && !mc_sel), "R8 irq", 64'(irq), 64'(m_sts && !mc_sel));
        chk(mcp == (m_sts && mc_sel), "R8 mcp", 64'(mcp), 64'(m_sts && mc_sel));
    endtask

    task automatic sink_err(input logic [1:0] r, input logic [7:0] flip, input logic [31:0] a);
        role = r; ta = 1; dbb = 0; sts_clr = 0;
        data_in = {$urandom, $urandom};
        par_in = odd_par(data_in) ^ flip;
        addr = a; attr = a[7:0] ^ 8'h5A;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_ABCD));
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        // R1 reset state
        chk({err_sts, err_ovf, irq, mcp} == 4'b0, "R1 flags", 64'({err_sts, err_ovf, irq, mcp}), 0);
        chk(err_lane == 0 && err_addr == 0 && err_attr == 0, "R1 captures",
            {err_addr, err_attr, err_lane, 16'h0}, 0);
        // R5 first error, lane 3 on master read
        sink_err(2'd0, 8'h08, 32'hA000_0010); step();
        // R6 second error while set: overflow, frozen
        sink_err(2'd3, 8'h81, 32'hB000_0020); step();
        // R8 routing switch while held
        ta = 0; mc_sel = 1; step();
        mc_sel = 0; step();
        // R7 clear alone
        sts_clr = 1; ta = 0; step();
        sts_clr = 0;
        sink_err(2'd3, 8'h01, 32'hC000_0030); step();
        // R7 clear and error in same cycle: error wins
        sink_err(2'd0, 8'hF0, 32'hD000_0040); sts_clr = 1; step();
        sts_clr = 1; ta = 0; step();
        // R9 disabled check
        chk_en = 0; sink_err(2'd0, 8'hFF, 32'hE000_0050); step();
        chk_en = 1;
        // R10 bad parity in source roles and without ta
        sink_err(2'd1, 8'h10, 32'h1); step();
        sink_err(2'd2, 8'h20, 32'h2); step();
        sink_err(2'd0, 8'h40, 32'h3); ta = 0; step();
        // random mix
        for (int n = 0; n < 3000; n++) begin
            role = 2'($urandom);
            dbb = 1'($urandom); ta = 1'($urandom);
            data_out = {$urandom, $urandom};
            data_in = {$urandom, $urandom};
            par_in = odd_par(data_in) ^ (($urandom % 4 == 0) ? 8'($urandom) : 8'h00);
            addr = $urandom; attr = 8'($urandom);
            chk_en = ($urandom % 8) != 0;
            mc_sel = ($urandom % 16 == 0) ? ~mc_sel : mc_sel;
            sts_clr = ($urandom % 8) == 0;
            step();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule